// File: doc/BRIEF.md
# 64-bit Integer ALU with Three-Way Compare

This block is a purely combinational 64-bit integer execution unit for a bytecode interpreter pipeline. An 8-bit opcode selects the operation. The first operand always comes from `src_a`. The second comes either from `src_b_reg` (register forms) or from `src_imm` (immediate forms). The block picks the second operand itself from the opcode, so the register and immediate variants of an operation share one adder, one multiplier, one shifter and one comparator.

It covers the following operations:
- wrapping add, subtract and multiply;
- AND, OR and XOR;
- logical left shift, logical right shift and arithmetic right shift;
- signed and unsigned comparison;
- bitwise complement and logical negation.

A comparison does not produce flags. It produces an ordinary 64-bit value: minus one, zero or plus one. The caller can store that value like any other result. Opcodes outside the supported set drive a zero result and raise `unsupported`, so the surrounding logic can trap.

Top module: `int_alu64`

## Requirements
- R1: Opcode 1 adds, opcode 2 subtracts (`src_a - b`), opcode 3 multiplies. Opcode 15 adds and opcode 16 multiplies with `src_imm`. Every result is the low 64 bits of the exact value.
- R2: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of `src_a` and `src_b_reg`. Opcodes 17, 18 and 19 do the same with `src_imm`.
- R3: Opcode 7/20 shifts left and opcode 8/21 shifts right, both filling with zeros. Opcode 9/22 shifts right, filling with bit 63 of `src_a`. The shift amount is bits [5:0] of the second operand only.
- R4: Opcode 10 (register) and opcode 23 (immediate) compare the operands as two's-complement values. The result is all-ones when `src_a` is smaller, zero when the operands are equal and 1 when `src_a` is larger.
- R5: Opcodes 11 and 24 compare as unsigned values and use the same three result encodings as R4.
- R6: Opcode 13 returns the bitwise complement of `src_a`. Neither second-operand input affects the result.
- R7: Opcode 14 returns 1 when `src_a` is zero and 0 otherwise.
- R8: Opcodes 15 to 24 ignore `src_b_reg`. Opcodes 1 to 11 ignore `src_imm`.
- R9: For every opcode not listed in R1–R7 (including 0, 12 and 25–255), `result` is 0 and `unsupported` is 1. For every listed opcode, `unsupported` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 8 | Operation code |
| src_a | input | 64 | First operand |
| src_b_reg | input | 64 | Second operand for register forms |
| src_imm | input | 64 | Second operand for immediate forms |
| result | output | 64 | Operation result |
| unsupported | output | 1 | High when the opcode is not implemented |

## Verification
Operand selection and the selected operation resolve in the same evaluation. The bench therefore always presents different values on `src_b_reg` and `src_imm` at once, across every opcode. A leak of the unselected operand into an add, shift or compare then shows up as a wrong result. A dedicated pass holds `src_a` and `src_imm` fixed and varies only `src_b_reg` under each immediate opcode; the result must not move. Every result is judged against a reference computed arithmetically in the bench, over a grid of edge operands: zero, one, all-ones, the signed extremes, and the shift counts 63 and 64.

// File: rtl/int_alu_pkg.sv
// Shared types for the 64-bit integer ALU: operation kinds and the
// decoded control word. Assumes opcodes are 8 bits wide.
package int_alu_pkg;

    localparam int OP_W = 8;

    typedef enum logic [3:0] {
        K_NONE,
        K_ADD,
        K_SUB,
        K_MUL,
        K_AND,
        K_OR,
        K_XOR,
        K_SHL,
        K_SHR,
        K_SRA,
        K_CMPS,
        K_CMPU,
        K_BNOT,
        K_LNOT
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      use_imm;
        logic      valid;
    } alu_ctl_t;

endpackage

// File: rtl/int_alu_decode.sv
// Opcode decoder. Maps an opcode to an operation kind, and flags whether
// the second operand comes from the immediate and whether the opcode is
// implemented. Assumes register and immediate forms share one kind.
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output alu_ctl_t        ctl
);

    // Purpose: translate the opcode into a control word.
    always_comb begin
        ctl = '{kind: K_NONE, use_imm: 1'b0, valid: 1'b0};
        unique case (op)
            8'd1:  ctl = '{kind: K_ADD,  use_imm: 1'b0, valid: 1'b1};
            8'd2:  ctl = '{kind: K_SUB,  use_imm: 1'b0, valid: 1'b1};
            8'd3:  ctl = '{kind: K_MUL,  use_imm: 1'b0, valid: 1'b1};
            8'd4:  ctl = '{kind: K_AND,  use_imm: 1'b0, valid: 1'b1};
            8'd5:  ctl = '{kind: K_OR,   use_imm: 1'b0, valid: 1'b1};
            8'd6:  ctl = '{kind: K_XOR,  use_imm: 1'b0, valid: 1'b1};
            8'd7:  ctl = '{kind: K_SHL,  use_imm: 1'b0, valid: 1'b1};
            8'd8:  ctl = '{kind: K_SHR,  use_imm: 1'b0, valid: 1'b1};
            8'd9:  ctl = '{kind: K_SRA,  use_imm: 1'b0, valid: 1'b1};
            8'd10: ctl = '{kind: K_CMPS, use_imm: 1'b0, valid: 1'b1};
            8'd11: ctl = '{kind: K_CMPU, use_imm: 1'b0, valid: 1'b1};
            8'd13: ctl = '{kind: K_BNOT, use_imm: 1'b0, valid: 1'b1};
            8'd14: ctl = '{kind: K_LNOT, use_imm: 1'b0, valid: 1'b1};
            8'd15: ctl = '{kind: K_ADD,  use_imm: 1'b1, valid: 1'b1};
            8'd16: ctl = '{kind: K_MUL,  use_imm: 1'b1, valid: 1'b1};
            8'd17: ctl = '{kind: K_AND,  use_imm: 1'b1, valid: 1'b1};
            8'd18: ctl = '{kind: K_OR,   use_imm: 1'b1, valid: 1'b1};
            8'd19: ctl = '{kind: K_XOR,  use_imm: 1'b1, valid: 1'b1};
            8'd20: ctl = '{kind: K_SHL,  use_imm: 1'b1, valid: 1'b1};
            8'd21: ctl = '{kind: K_SHR,  use_imm: 1'b1, valid: 1'b1};
            8'd22: ctl = '{kind: K_SRA,  use_imm: 1'b1, valid: 1'b1};
            8'd23: ctl = '{kind: K_CMPS, use_imm: 1'b1, valid: 1'b1};
            8'd24: ctl = '{kind: K_CMPU, use_imm: 1'b1, valid: 1'b1};
            default: ctl = '{kind: K_NONE, use_imm: 1'b0, valid: 1'b0};
        endcase
    end

    // Purpose: an unimplemented opcode never carries a live kind.
    always_comb begin
        if (!$isunknown(op)) begin
            assert_invalid_is_none_R9: assert (ctl.valid || ctl.kind == K_NONE)
                else $error("invalid opcode decoded to a live kind");
        end
    end

endmodule

// File: rtl/int_alu_shift.sv
// Logarithmic barrel shifter with left, logical right and arithmetic
// right modes. Assumes W is a power of two; only the low log2(W) bits
// of the amount exist at this boundary.
module int_alu_shift #(
    parameter int W  = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);

    logic [W-1:0] l_st [SW+1];
    logic [W-1:0] r_st [SW+1];
    logic         fill;

    // Purpose: choose the bit shifted into the vacated high positions.
    always_comb fill = arith & din[W-1];

    assign l_st[0] = din;
    assign r_st[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        // Purpose: stage i moves by 2^i when amount bit i is set.
        always_comb begin
            l_st[i+1] = amt[i] ? {l_st[i][W-1-STEP:0], {STEP{1'b0}}} : l_st[i];
            r_st[i+1] = amt[i] ? {{STEP{fill}}, r_st[i][W-1:STEP]}   : r_st[i];
        end
    end

    // Purpose: pick the direction.
    always_comb dout = left ? l_st[SW] : r_st[SW];

    // Purpose: a zero amount passes the operand unchanged in every mode.
    always_comb begin
        if (!$isunknown({din, amt, left, arith}) && amt == '0) begin
            assert_zero_shift_R3: assert (dout == din)
                else $error("zero shift altered operand");
        end
    end

endmodule

// File: rtl/int_alu_cmp.sv
// Three-way comparator. Returns all-ones, zero or one as a W-bit value
// for less, equal or greater; signed selects two's-complement ordering.
module int_alu_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         signed_cmp,
    output logic [W-1:0] order
);

    logic less;
    logic same;

    // Purpose: derive the ordering relation from the two operands.
    always_comb begin
        same = (lhs == rhs);
        if (signed_cmp) less = ($signed(lhs) < $signed(rhs));
        else            less = (lhs < rhs);
    end

    // Purpose: encode the relation as a signed integer.
    always_comb begin
        if (same)      order = '0;
        else if (less) order = '1;
        else           order = W'(1);
    end

    // Purpose: the encoding stays in the three legal values, and equal
    // operands yield zero whichever ordering is chosen.
    always_comb begin
        if (!$isunknown({lhs, rhs, signed_cmp})) begin
            assert_cmp_range_R4: assert (order == '0 || order == '1 || order == W'(1))
                else $error("compare produced illegal code");
            assert_cmp_equal_R5: assert (lhs != rhs || order == '0)
                else $error("equal operands gave nonzero order");
        end
    end

endmodule

// File: rtl/int_alu64.sv
// 64-bit combinational integer ALU. It decodes the opcode, picks the
// second operand from register or immediate input, and evaluates the
// selected arithmetic, bitwise, shift, compare or negation operation.
// Unimplemented opcodes give a zero result with `unsupported` set.
module int_alu64
    import int_alu_pkg::*;
#(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    src_a,
    input  logic [W-1:0]    src_b_reg,
    input  logic [W-1:0]    src_imm,
    output logic [W-1:0]    result,
    output logic            unsupported
);

    alu_ctl_t     ctl;
    logic [W-1:0] opnd_b;
    logic [W-1:0] shifted;
    logic [W-1:0] ordered;
    logic         shl;
    logic         sra;
    logic         cmp_signed;

    int_alu_decode u_dec (
        .op  (op),
        .ctl (ctl)
    );

    // Purpose: shared second-operand selection for both opcode forms.
    always_comb opnd_b = ctl.use_imm ? src_imm : src_b_reg;

    // Purpose: shifter and comparator mode controls.
    always_comb begin
        shl        = (ctl.kind == K_SHL);
        sra        = (ctl.kind == K_SRA);
        cmp_signed = (ctl.kind == K_CMPS);
    end

    int_alu_shift #(.W(W)) u_shift (
        .din   (src_a),
        .amt   (opnd_b[SW-1:0]),
        .left  (shl),
        .arith (sra),
        .dout  (shifted)
    );

    int_alu_cmp #(.W(W)) u_cmp (
        .lhs        (src_a),
        .rhs        (opnd_b),
        .signed_cmp (cmp_signed),
        .order      (ordered)
    );

    // Purpose: select the output for the decoded operation kind.
    always_comb begin
        unique case (ctl.kind)
            K_ADD:  result = src_a + opnd_b;
            K_SUB:  result = src_a - opnd_b;
            K_MUL:  result = src_a * opnd_b;
            K_AND:  result = src_a & opnd_b;
            K_OR:   result = src_a | opnd_b;
            K_XOR:  result = src_a ^ opnd_b;
            K_SHL, K_SHR, K_SRA: result = shifted;
            K_CMPS, K_CMPU:      result = ordered;
            K_BNOT: result = ~src_a;
            K_LNOT: result = W'(src_a == '0);
            default: result = '0;
        endcase
        unsupported = ~ctl.valid;
    end

    // Purpose: guard the opcode-level contracts at the top boundary.
    always_comb begin
        if (!$isunknown({op, src_a, src_b_reg, src_imm})) begin
            assert_unsup_zero_R9: assert (!unsupported || result == '0)
                else $error("unsupported opcode with nonzero result");
            assert_lnot_bool_R7: assert (op != 8'd14 || result[W-1:1] == '0)
                else $error("logical negation not boolean");
            assert_bnot_inv_R6: assert (op != 8'd13 || (result ^ src_a) == '1)
                else $error("complement mismatch");
        end
    end

endmodule

// File: tb/sim_int_alu64.sv
module sim_int_alu64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op;
    logic [63:0] src_a, src_b_reg, src_imm;
    logic [63:0] result;
    logic        unsupported;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [63:0] vals [8];

    always #2.5 clk = ~clk;

    int_alu64 u0 (
        .op          (op),
        .src_a       (src_a),
        .src_b_reg   (src_b_reg),
        .src_imm     (src_imm),
        .result      (result),
        .unsupported (unsupported)
    );

    function automatic string req_of(int o);
        case (o)
            1, 2, 3, 15, 16:         return "R1";
            4, 5, 6, 17, 18, 19:     return "R2";
            7, 8, 9, 20, 21, 22:     return "R3";
            10, 23:                  return "R4";
            11, 24:                  return "R5";
            13:                      return "R6";
            14:                      return "R7";
            default:                 return "R9";
        endcase
    endfunction

    // Reference: {unsupported, result} from the requirement text.
    function automatic logic [64:0] ref_model(int o, logic [63:0] a,
                                              logic [63:0] br, logic [63:0] im);
        logic [63:0] b;
        logic [127:0] prod;
        int sh;
        b = (o >= 15 && o <= 24) ? im : br;
        sh = int'(b % 64);
        case (o)
            1, 15:  return {1'b0, a + b};
            2:      return {1'b0, a - b};
            3, 16:  begin prod = {64'd0, a} * {64'd0, b}; return {1'b0, prod[63:0]}; end
            4, 17:  return {1'b0, a & b};
            5, 18:  return {1'b0, a | b};
            6, 19:  return {1'b0, a ^ b};
            7, 20:  return {1'b0, a << sh};
            8, 21:  return {1'b0, a >> sh};
            9, 22:  return {1'b0, 64'($signed(a) >>> sh)};
            10, 23: return {1'b0, ($signed(a) < $signed(b)) ? 64'hFFFF_FFFF_FFFF_FFFF :
                                  (a == b) ? 64'd0 : 64'd1};
            11, 24: return {1'b0, (a < b) ? 64'hFFFF_FFFF_FFFF_FFFF :
                                  (a == b) ? 64'd0 : 64'd1};
            13:     return {1'b0, ~a};
            14:     return {1'b0, (a == 64'd0) ? 64'd1 : 64'd0};
            default: return {1'b1, 64'd0};
        endcase
    endfunction

    task automatic apply_check(int o, logic [63:0] a, logic [63:0] br,
                               logic [63:0] im, string tag);
        logic [64:0] exp;
        @(negedge clk);
        op = 8'(o); src_a = a; src_b_reg = br; src_imm = im;
        #1;
        exp = ref_model(o, a, br, im);
        n_run++;
        if ({unsupported, result} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h : actual %b/%h expected %b/%h",
                     tag, o, a, br, im, unsupported, result, exp[64], exp[63:0]);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        vals[0] = 64'd0;
        vals[1] = 64'd1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h8000_0000_0000_0000;
        vals[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[5] = 64'd63;
        vals[6] = 64'd64;
        vals[7] = 64'hDEAD_BEEF_0123_4567;
        op = '0; src_a = '0; src_b_reg = '0; src_imm = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: opcode 0 with zero operands (R9).
        apply_check(0, 64'd0, 64'd0, 64'd0, "R9");

        // Main sweep: every opcode 0..31 and 255 over the operand grid,
        // with differing register and immediate second operands.
        for (int o = 0; o < 33; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    apply_check((o == 32) ? 255 : o, vals[i], vals[j],
                                vals[(j + 3) % 8], req_of((o == 32) ? 255 : o));
                end
            end
        end

        // R8: immediate forms ignore src_b_reg; register forms ignore src_imm.
        for (int o = 15; o <= 24; o++) begin
            for (int j = 0; j < 8; j++)
                apply_check(o, vals[7], vals[j], 64'd5, "R8");
        end
        for (int o = 1; o <= 11; o++) begin
            for (int j = 0; j < 8; j++)
                apply_check(o, vals[3], 64'd3, vals[j], "R8");
        end

        // Directed corners.
        apply_check(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd0, "R1");
        apply_check(16, 64'h1_0000_0001, 64'd0, 64'h1_0000_0001, "R1");
        apply_check(9, 64'h8000_0000_0000_0000, 64'd127, 64'd0, "R3");
        apply_check(10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, "R4");
        apply_check(11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, "R5");
        apply_check(14, 64'd0, 64'd9, 64'd9, "R7");
        apply_check(12, 64'd7, 64'd2, 64'd0, "R9");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule